// File: doc/BRIEF.md
# Bus Cycle Termination and Halt Controller

This block runs the external bus cycles of a 16-bit bus master and decides how each cycle ends. The core hands it one request at a time. The request carries an address, a function code, a size, a direction and two flags: one marks an interrupt acknowledge, the other marks an access that stays inside the chip. For an external request the controller drives the address and the strobes. It then watches the data/size acknowledge pair, the autovector line, the bus error line and a built-in timeout monitor. It returns exactly one two-bit result code, with read data when there is any.

Halt is handled in two ways. Halt together with bus error turns a faulted cycle into a retry. Halt on its own lets one cycle run and then parks the bus: the strobes go inactive and the data drivers turn off, while address, function code, size and direction keep their values. When an external master is granted the bus, this controller stops driving and its timeout monitor stays idle. Every external pin is active low and passes through a two-flop synchronizer before any decision uses it.

Top module: `bus_term_ctrl`

## Requirements
- R1: A cycle whose only terminator is either `dsack_n` bit low ends with `rsp_code` 2'b00, and a read (`rw_o` = 1) returns `data_i` on `rsp_rdata`.
- R2: `berr_n` low without halt ends the cycle with code 2'b10, also when a data/size acknowledge arrives at the same time.
- R3: With no terminator, the monitor ends a cycle with code 2'b10 exactly 16 << `tmo_sel` clock cycles after the request is accepted. The monitor never expires while an external master holds the bus (`bgrant_n` low).
- R4: `berr_n` and `halt_n` low together end the cycle with code 2'b11 (retry).
- R5: `avec_n` low ends an interrupt acknowledge cycle with code 2'b01. On any other cycle `avec_n` has no effect, so the cycle runs to the monitor timeout (code 2'b10).
- R6: A cycle that completes while `halt_n` is low leaves the bus parked: `as_n` and `ds_n` high, `data_oe` low, and `addr_o`, `fc_o`, `siz_o`, `rw_o` held. No further external request is accepted until halt is released.
- R7: While idle or parked, a low `bgrant_n` drops `bus_oe`. If halt is still low when the grant is withdrawn, `bus_oe` returns high with the held address, function code, size and direction.
- R8: `irq_take` stays low while the controller is parked by halt, even with `irq_pend` high.
- R9: An internal request (`req_internal` = 1) is answered on the next cycle with code 2'b00 and zero data, whether or not halt is asserted.
- R10: Each accepted request (`req_valid` and `req_ready` high on a clock edge) gets exactly one `rsp_valid` pulse.
- R11: After reset `as_n` and `ds_n` are high, `data_oe` and `rsp_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Core request strobe |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_internal | input | 1 | Access stays on chip, no bus cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_iack | input | 1 | Request is an interrupt acknowledge |
| req_addr | input | 24 | Request address |
| req_fc | input | 3 | Request function code |
| req_size | input | 2 | Request transfer size |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_code | output | 2 | 00 normal, 01 autovector, 10 bus error, 11 retry |
| rsp_rdata | output | 16 | Read data |
| tmo_sel | input | 2 | Monitor timeout select, 16 << tmo_sel cycles |
| irq_pend | input | 1 | Interrupt request pending |
| irq_take | output | 1 | Interrupt request accepted |
| dsack_n | input | 2 | Data/size acknowledge, active low |
| avec_n | input | 1 | Autovector, active low |
| berr_n | input | 1 | Bus error, active low |
| halt_n | input | 1 | Halt, active low |
| bgrant_n | input | 1 | Bus granted to external master, active low |
| data_i | input | 16 | Data bus input |
| addr_o | output | 24 | Address bus |
| fc_o | output | 3 | Function code |
| siz_o | output | 2 | Transfer size |
| rw_o | output | 1 | 1 = read, 0 = write |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| data_o | output | 16 | Data bus output |
| data_oe | output | 1 | Data bus drive enable |
| bus_oe | output | 1 | Address, control and strobe drive enable |

## Verification
Bus error can arrive together with either a data/size acknowledge or halt, and the result then depends on precedence. The bench provokes both pairings by asserting the two pins on the same clock, so that they leave the synchronizers in the same cycle. It expects 2'b10 for bus error with acknowledge and 2'b11 for bus error with halt. The retry case is then followed until the controller is parked, to confirm that the address stays held and that interrupts stay blocked until halt is released.

// File: rtl/bus_term_pkg.sv
// Shared types for the bus cycle termination controller.
// Assumes: two-bit result code seen by the core, four sequencer states.
package bus_term_pkg;

    typedef enum logic [1:0] {
        RSP_OK      = 2'b00,
        RSP_AUTOVEC = 2'b01,
        RSP_BUSERR  = 2'b10,
        RSP_RETRY   = 2'b11
    } rsp_code_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_RECOVER = 2'd2,
        ST_HALTED  = 2'd3
    } seq_state_t;

endpackage

// File: rtl/bt_sync.sv
// Two-flop synchronizer for a vector of asynchronous pins.
// Assumes: each bit is independent; RST_VAL is the inactive pin level.
module bt_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // two register stages per bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/bt_bus_monitor.sv
// Bus cycle timeout monitor. Counts clock cycles of an own bus cycle and
// flags expiry after BASE << sel cycles.
// Assumes: start pulses on the accept edge; run is high only for own cycles.
module bt_bus_monitor #(
    parameter int BASE  = 16,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             expired
);
    localparam int CNT_W = $clog2(BASE) + (1 << SEL_W);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    // limit is the selected count minus one, as the first active cycle sees zero
    always_comb begin
        lim = CNT_W'((32'(BASE) << sel) - 32'd1);
    end

    assign expired = run && (cnt == lim);

    // counter cleared at every cycle start, advanced while the cycle runs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= '0;
        end else if (run && !expired) begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/bt_seq.sv
// Bus cycle sequencer: accepts core requests, runs external cycles, picks
// the termination and parks the bus under halt.
// Assumes: all pin inputs are already synchronized and active high here.
module bt_seq
    import bus_term_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_internal,
    input  logic          req_write,
    input  logic          req_iack,
    input  logic [AW-1:0] req_addr,
    input  logic [2:0]    req_fc,
    input  logic [1:0]    req_size,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [1:0]    rsp_code,
    output logic [DW-1:0] rsp_rdata,
    input  logic          irq_pend,
    output logic          irq_take,
    input  logic          dsack_s,
    input  logic          avec_s,
    input  logic          berr_s,
    input  logic          halt_s,
    input  logic          grant_s,
    input  logic [DW-1:0] data_i,
    input  logic          mon_expired,
    output logic          mon_start,
    output logic          mon_run,
    output logic [AW-1:0] addr_q,
    output logic [2:0]    fc_q,
    output logic [1:0]    size_q,
    output logic          rw_q,
    output logic [DW-1:0] wdata_q,
    output logic          as_n,
    output logic          ds_n,
    output logic          data_oe,
    output logic          bus_oe,
    output logic          st_active,
    output logic          st_halted,
    output logic          cyc_iack
);
    seq_state_t state;
    logic       st_idle;
    logic       acc_ext;
    logic       acc_int;
    logic       term;
    rsp_code_t  term_code;
    logic       settled;

    assign st_idle   = (state == ST_IDLE);
    assign st_active = (state == ST_ACTIVE);
    assign st_halted = (state == ST_HALTED);

    // request acceptance: internal accesses bypass halt and the bus owner
    always_comb begin
        if (req_internal) begin
            req_ready = st_idle || st_halted;
        end else begin
            req_ready = st_idle && !grant_s;
        end
    end

    assign acc_ext = req_valid && req_ready && !req_internal;
    assign acc_int = req_valid && req_ready && req_internal;

    // termination priority: bus error (retry with halt), timeout, autovector, acknowledge
    always_comb begin
        term      = 1'b0;
        term_code = RSP_OK;
        if (berr_s) begin
            term      = 1'b1;
            term_code = halt_s ? RSP_RETRY : RSP_BUSERR;
        end else if (mon_expired) begin
            term      = 1'b1;
            term_code = RSP_BUSERR;
        end else if (avec_s && cyc_iack) begin
            term      = 1'b1;
            term_code = RSP_AUTOVEC;
        end else if (dsack_s) begin
            term      = 1'b1;
            term_code = RSP_OK;
        end
    end

    // terminators that must fall before the next cycle may start
    assign settled = !dsack_s && !berr_s;

    // sequencer state transitions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:    if (acc_ext) state <= ST_ACTIVE;
                ST_ACTIVE:  if (term) state <= ST_RECOVER;
                ST_RECOVER: if (settled) state <= halt_s ? ST_HALTED : ST_IDLE;
                ST_HALTED:  if (!halt_s) state <= ST_IDLE;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    // cycle attributes latched at acceptance and held until the next cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            fc_q     <= '0;
            size_q   <= '0;
            rw_q     <= 1'b1;
            wdata_q  <= '0;
            cyc_iack <= 1'b0;
        end else if (acc_ext) begin
            addr_q   <= req_addr;
            fc_q     <= req_fc;
            size_q   <= req_size;
            rw_q     <= !req_write;
            wdata_q  <= req_wdata;
            cyc_iack <= req_iack;
        end
    end

    // single response pulse per accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_code  <= RSP_OK;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= acc_int || (st_active && term);
            if (acc_int) begin
                rsp_code  <= RSP_OK;
                rsp_rdata <= '0;
            end else if (st_active && term) begin
                rsp_code  <= term_code;
                rsp_rdata <= (term_code == RSP_OK && rw_q) ? data_i : '0;
            end
        end
    end

    assign mon_start = acc_ext;
    assign mon_run   = st_active;
    assign as_n      = !st_active;
    assign ds_n      = !st_active;
    assign data_oe   = st_active && !rw_q;
    assign bus_oe    = !((st_idle || st_halted) && grant_s);
    assign irq_take  = irq_pend && !st_halted;
endmodule

// File: rtl/bus_term_ctrl.sv
// Top of the bus cycle termination and halt controller: synchronizes the
// external pins, runs the timeout monitor and the cycle sequencer.
// Assumes: all external control pins are active low and asynchronous.
module bus_term_ctrl #(
    parameter int AW        = 24,
    parameter int DW        = 16,
    parameter int TMO_BASE  = 16,
    parameter int TMO_SEL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_internal,
    input  logic                 req_write,
    input  logic                 req_iack,
    input  logic [AW-1:0]        req_addr,
    input  logic [2:0]           req_fc,
    input  logic [1:0]           req_size,
    input  logic [DW-1:0]        req_wdata,
    output logic                 rsp_valid,
    output logic [1:0]           rsp_code,
    output logic [DW-1:0]        rsp_rdata,
    input  logic [TMO_SEL_W-1:0] tmo_sel,
    input  logic                 irq_pend,
    output logic                 irq_take,
    input  logic [1:0]           dsack_n,
    input  logic                 avec_n,
    input  logic                 berr_n,
    input  logic                 halt_n,
    input  logic                 bgrant_n,
    input  logic [DW-1:0]        data_i,
    output logic [AW-1:0]        addr_o,
    output logic [2:0]           fc_o,
    output logic [1:0]           siz_o,
    output logic                 rw_o,
    output logic                 as_n,
    output logic                 ds_n,
    output logic [DW-1:0]        data_o,
    output logic                 data_oe,
    output logic                 bus_oe
);
    localparam int PIN_W = 6;

    logic [PIN_W-1:0] pins_s;
    logic             dsack_s;
    logic             avec_s;
    logic             berr_s;
    logic             halt_s;
    logic             grant_s;
    logic             mon_start;
    logic             mon_run;
    logic             mon_expired;
    logic             st_active;
    logic             st_halted;
    logic             cyc_iack;

    bt_sync #(
        .W       (PIN_W),
        .RST_VAL ({PIN_W{1'b1}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({dsack_n, avec_n, berr_n, halt_n, bgrant_n}),
        .q     (pins_s)
    );

    // synchronized pins converted to active-high terms
    assign dsack_s = ~&pins_s[5:4];
    assign avec_s  = ~pins_s[3];
    assign berr_s  = ~pins_s[2];
    assign halt_s  = ~pins_s[1];
    assign grant_s = ~pins_s[0];

    bt_bus_monitor #(
        .BASE  (TMO_BASE),
        .SEL_W (TMO_SEL_W)
    ) u_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (mon_start),
        .run     (mon_run),
        .sel     (tmo_sel),
        .expired (mon_expired)
    );

    bt_seq #(
        .AW (AW),
        .DW (DW)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_internal (req_internal),
        .req_write    (req_write),
        .req_iack     (req_iack),
        .req_addr     (req_addr),
        .req_fc       (req_fc),
        .req_size     (req_size),
        .req_wdata    (req_wdata),
        .rsp_valid    (rsp_valid),
        .rsp_code     (rsp_code),
        .rsp_rdata    (rsp_rdata),
        .irq_pend     (irq_pend),
        .irq_take     (irq_take),
        .dsack_s      (dsack_s),
        .avec_s       (avec_s),
        .berr_s       (berr_s),
        .halt_s       (halt_s),
        .grant_s      (grant_s),
        .data_i       (data_i),
        .mon_expired  (mon_expired),
        .mon_start    (mon_start),
        .mon_run      (mon_run),
        .addr_q       (addr_o),
        .fc_q         (fc_o),
        .size_q       (siz_o),
        .rw_q         (rw_o),
        .wdata_q      (data_o),
        .as_n         (as_n),
        .ds_n         (ds_n),
        .data_oe      (data_oe),
        .bus_oe       (bus_oe),
        .st_active    (st_active),
        .st_halted    (st_halted),
        .cyc_iack     (cyc_iack)
    );
endmodule

// File: rtl/bt_checker.sv
// Property checker for bus_term_ctrl, attached by bind.
// Assumes: connected to the top's ports and its internal decision signals.
module bt_checker #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [1:0]    rsp_code,
    input logic          irq_take,
    input logic [AW-1:0] addr_o,
    input logic [2:0]    fc_o,
    input logic [1:0]    siz_o,
    input logic          rw_o,
    input logic          as_n,
    input logic          ds_n,
    input logic          data_oe,
    input logic          bus_oe,
    input logic          berr_s,
    input logic          halt_s,
    input logic          mon_expired,
    input logic          st_active,
    input logic          st_halted,
    input logic          cyc_iack
);
    logic pend;

    // tracks whether an accepted request still awaits its response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (req_valid && req_ready) begin
            pend <= 1'b1;
        end else if (rsp_valid) begin
            pend <= 1'b0;
        end
    end

    AST_BERR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_active && berr_s && !halt_s) |=> (rsp_valid && rsp_code == 2'b10)); // R2

    AST_MON_OWN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> !mon_expired); // R3

    AST_RETRY_ON_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_active && berr_s && halt_s) |=> (rsp_valid && rsp_code == 2'b11)); // R4

    AST_AVEC_IACK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'b01) |-> cyc_iack); // R5

    AST_HALT_STROBES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        st_halted |-> (as_n && ds_n && !data_oe)); // R6

    AST_HALT_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (st_halted && $past(st_halted)) |->
            ($stable(addr_o) && $stable(fc_o) && $stable(siz_o) && $stable(rw_o))); // R6

    AST_NO_IRQ_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        st_halted |-> !irq_take); // R8

    AST_RSP_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> pend); // R10
endmodule

bind bus_term_ctrl bt_checker #(.AW(AW)) u_bt_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_code    (rsp_code),
    .irq_take    (irq_take),
    .addr_o      (addr_o),
    .fc_o        (fc_o),
    .siz_o       (siz_o),
    .rw_o        (rw_o),
    .as_n        (as_n),
    .ds_n        (ds_n),
    .data_oe     (data_oe),
    .bus_oe      (bus_oe),
    .berr_s      (berr_s),
    .halt_s      (halt_s),
    .mon_expired (mon_expired),
    .st_active   (st_active),
    .st_halted   (st_halted),
    .cyc_iack    (cyc_iack)
);

// File: tb/test_bus_term_ctrl.sv
module test_bus_term_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_internal = 1'b0;
    logic        req_write = 1'b0;
    logic        req_iack = 1'b0;
    logic [23:0] req_addr = '0;
    logic [2:0]  req_fc = '0;
    logic [1:0]  req_size = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_code;
    logic [15:0] rsp_rdata;
    logic [1:0]  tmo_sel = '0;
    logic        irq_pend = 1'b0;
    logic        irq_take;
    logic [1:0]  dsack_n = 2'b11;
    logic        avec_n = 1'b1;
    logic        berr_n = 1'b1;
    logic        halt_n = 1'b1;
    logic        bgrant_n = 1'b1;
    logic [15:0] data_i = '0;
    logic [23:0] addr_o;
    logic [2:0]  fc_o;
    logic [1:0]  siz_o;
    logic        rw_o;
    logic        as_n;
    logic        ds_n;
    logic [15:0] data_o;
    logic        data_oe;
    logic        bus_oe;

    int checks = 0;
    int errors = 0;

    localparam int K_DSACK = 0, K_AVEC = 1, K_BERR = 2, K_BERR_DSACK = 3,
                   K_BERR_HALT = 4, K_NONE = 5, K_INTERNAL = 6;

    always #2 clk = ~clk;

    bus_term_ctrl i_bus_term_ctrl (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_sim();
    end

    function automatic logic [1:0] exp_code(input int kind, input bit iack);
        case (kind)
            K_DSACK:     return 2'b00;
            K_AVEC:      return iack ? 2'b01 : 2'b10;
            K_BERR:      return 2'b10;
            K_BERR_DSACK:return 2'b10;
            K_BERR_HALT: return 2'b11;
            K_NONE:      return 2'b10;
            default:     return 2'b00;
        endcase
    endfunction

    // present one request and return right after the accepting edge
    task automatic send(input bit internal, input bit write, input bit iack,
                        input logic [23:0] a, input logic [15:0] d);
        @(negedge clk);
        req_internal = internal;
        req_write    = write;
        req_iack     = iack;
        req_addr     = a;
        req_fc       = a[2:0];
        req_size     = a[4:3];
        req_wdata    = d;
        for (int i = 0; i < 1000 && !req_ready; i++) @(negedge clk);
        req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic wait_rsp(output bit seen, output logic [1:0] code,
                            output logic [15:0] rd);
        seen = 1'b0;
        code = '0;
        rd   = '0;
        for (int i = 0; i < 600; i++) begin
            if (rsp_valid) begin
                seen = 1'b1;
                code = rsp_code;
                rd   = rsp_rdata;
                break;
            end
            @(posedge clk);
            #1;
        end
    endtask

    task automatic release_pins(input bit keep_halt);
        dsack_n = 2'b11;
        avec_n  = 1'b1;
        berr_n  = 1'b1;
        if (!keep_halt) halt_n = 1'b1;
    endtask

    // run one transaction of a given termination kind and judge the result
    task automatic run_txn(input int kind, input bit iack, input bit write,
                           input logic [23:0] a, input logic [15:0] d);
        bit          seen;
        logic [1:0]  code;
        logic [15:0] rd;
        logic [15:0] bus_rd;
        logic [1:0]  expc;
        bus_rd = d ^ 16'h5a5a;
        send(kind == K_INTERNAL, write, iack, a, d);
        case (kind)
            K_DSACK:      begin data_i = bus_rd; dsack_n = 2'b10; end
            K_AVEC:       avec_n = 1'b0;
            K_BERR:       berr_n = 1'b0;
            K_BERR_DSACK: begin berr_n = 1'b0; dsack_n = 2'b00; end
            K_BERR_HALT:  begin berr_n = 1'b0; halt_n = 1'b0; end
            default: ;
        endcase
        wait_rsp(seen, code, rd);
        release_pins(kind == K_BERR_HALT);
        expc = exp_code(kind, iack);
        if (kind == K_INTERNAL) begin
            check(seen && code == 2'b00 && rd == 16'h0, "R9", "internal response",
                  {14'h0, code, rd}, 32'h0);
        end else if (kind == K_BERR || kind == K_BERR_DSACK) begin
            check(seen && code == expc, "R2", "bus error code", {31'h0, seen} << 2 | code, 32'h6);
        end else if (kind == K_BERR_HALT) begin
            check(seen && code == expc, "R4", "retry code", {29'h0, seen, code}, 32'h7);
        end else if (kind == K_AVEC) begin
            check(seen && code == expc, "R5", "autovector code", {29'h0, seen, code},
                  {29'h0, 1'b1, expc});
        end else if (kind == K_NONE) begin
            check(seen && code == expc, "R3", "timeout code", {29'h0, seen, code}, 32'h6);
        end else begin
            check(seen && code == expc, "R1", "normal code", {29'h0, seen, code}, 32'h4);
            if (!write) check(rd == bus_rd, "R1", "read data", {16'h0, rd}, {16'h0, bus_rd});
        end
        if (kind == K_BERR_HALT) begin
            irq_pend = 1'b1;
            repeat (6) @(posedge clk);
            #1;
            check(as_n && !data_oe && bus_oe && addr_o == a, "R6", "parked after retry",
                  {7'h0, as_n, addr_o}, {8'h1, a});
            check(!irq_take, "R8", "irq while parked", {31'h0, irq_take}, 32'h0);
            irq_pend = 1'b0;
            halt_n = 1'b1;
        end
        repeat (6) @(posedge clk);
    endtask

    initial begin
        bit          seen;
        logic [1:0]  code;
        logic [15:0] rd;
        int          n;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        #1;
        check(as_n && ds_n && !data_oe && !rsp_valid, "R11", "reset outputs",
              {28'h0, as_n, ds_n, data_oe, rsp_valid}, 32'hC);
        check(req_ready, "R11", "ready under reset", {31'h0, req_ready}, 32'h1);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        check(req_ready && as_n, "R11", "ready after reset", {30'h0, req_ready, as_n}, 32'h3);

        // directed terminations
        run_txn(K_DSACK, 1'b0, 1'b0, 24'h001234, 16'h1111);
        run_txn(K_DSACK, 1'b0, 1'b1, 24'h00abcd, 16'h2222);
        run_txn(K_BERR_DSACK, 1'b0, 1'b0, 24'h000100, 16'h3333);
        run_txn(K_BERR, 1'b0, 1'b1, 24'h000200, 16'h4444);
        run_txn(K_BERR_HALT, 1'b0, 1'b0, 24'h000300, 16'h5555);
        run_txn(K_AVEC, 1'b1, 1'b0, 24'hfffff8, 16'h0);
        run_txn(K_AVEC, 1'b0, 1'b0, 24'h000400, 16'h0);
        run_txn(K_INTERNAL, 1'b0, 1'b0, 24'h000500, 16'h0);

        // monitor timeout length for each select value
        for (int s = 0; s < 4; s++) begin
            tmo_sel = 2'(s);
            send(1'b0, 1'b0, 1'b0, 24'h000600, 16'h0);
            n = 0;
            while (n < 400) begin
                @(posedge clk);
                n++;
                #1;
                if (rsp_valid) break;
            end
            check(n == (16 << s) && rsp_code == 2'b10, "R3", "timeout length",
                  32'(n), 32'(16 << s));
            repeat (4) @(posedge clk);
        end
        tmo_sel = '0;

        // external master holds the bus: no drive, no timeout, no acceptance
        @(negedge clk);
        bgrant_n = 1'b0;
        req_internal = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        check(!bus_oe && !req_ready, "R7", "bus released to external master",
              {30'h0, bus_oe, req_ready}, 32'h0);
        n = 0;
        for (int i = 0; i < 300; i++) begin
            @(posedge clk);
            #1;
            if (rsp_valid) n++;
        end
        check(n == 0, "R3", "no monitor response under grant", 32'(n), 32'h0);
        bgrant_n = 1'b1;
        repeat (4) @(posedge clk);

        // halt-driven single step
        halt_n = 1'b0;
        repeat (4) @(posedge clk);
        send(1'b0, 1'b1, 1'b0, 24'h0a0b0c, 16'hbeef);
        dsack_n = 2'b00;
        wait_rsp(seen, code, rd);
        release_pins(1'b1);
        check(seen && code == 2'b00, "R1", "step cycle code", {29'h0, seen, code}, 32'h4);
        repeat (5) @(posedge clk);
        #1;
        check(as_n && ds_n && !data_oe, "R6", "strobes off when parked",
              {29'h0, as_n, ds_n, data_oe}, 32'h6);
        check(addr_o == 24'h0a0b0c && fc_o == 3'h4 && siz_o == 2'h1 && rw_o == 1'b0,
              "R6", "attributes held", {8'h0, addr_o}, 32'h0a0b0c);
        req_internal = 1'b0;
        #0;
        check(!req_ready, "R6", "external request blocked", {31'h0, req_ready}, 32'h0);
        send(1'b1, 1'b0, 1'b0, 24'h000777, 16'h0);
        wait_rsp(seen, code, rd);
        check(seen && code == 2'b00, "R9", "internal under halt", {29'h0, seen, code}, 32'h4);
        req_internal = 1'b0;
        bgrant_n = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        check(!bus_oe, "R7", "grant while parked", {31'h0, bus_oe}, 32'h0);
        bgrant_n = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        check(bus_oe && addr_o == 24'h0a0b0c && rw_o == 1'b0, "R7", "held values driven again",
              {7'h0, bus_oe, addr_o}, 32'h010a0b0c);
        halt_n = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        check(req_ready, "R6", "ready after halt release", {31'h0, req_ready}, 32'h1);

        // constrained random mix
        for (int t = 0; t < 60; t++) begin
            int          kind;
            bit          iack;
            bit          wr;
            logic [23:0] a;
            kind = $urandom_range(0, 6);
            iack = 1'($urandom_range(0, 1));
            wr   = iack ? 1'b0 : 1'($urandom_range(0, 1));
            a    = 24'($urandom);
            run_txn(kind, iack, wr, a, 16'($urandom));
        end
        check(!rsp_valid, "R10", "no stray response", {31'h0, rsp_valid}, 32'h0);
        finish_sim();
    end
endmodule